// File: doc/BRIEF.md
# DMA Channel Handshake and Reset Glue

This block sits between one DMA channel's external handshake pins and the channel core. It cleans up the incoming request pin and turns it into a request to the channel arbiter. The pin is first brought into the clock domain. Software then picks which pin level counts as active, and whether a request is seen as a level or as an edge. An edge is kept as a pending request until the arbiter grants it. The block also drives the acknowledge pin at a chosen polarity, and it owns the active-low done pin.

The done pin has four operating modes, selected by a 2-bit field:

- **Ignored:** the pin is an input and its value has no effect.
- **Input:** an external done is seen and acted on.
- **Output:** the block pulses done at terminal count.
- **Open-drain:** the block pulls done low at terminal count and also listens for other devices pulling it low.

An external done aborts work. A chain selector decides whether it ends only the current register-set transfer or the whole chained transfer.

A channel-reset control input holds the channel cleared while it is high. This clears enable, transfer-active, done status, pending requests, abort pulses and acknowledge. The register bit that feeds this input comes out of chip reset at 1, so the channel stays idle until software writes it to 0. All other control fields reset to 0 in that register file.

Top module: `dmahs_chan`

## Requirements
- R1: With `req_edge`=0 and `req_pol`=1, a high `req_pin` produces `arb_req`=1 after two clock edges of synchronization, provided the channel is enabled and not in channel reset. A low pin gives `arb_req`=0.
- R2: With `req_pol`=0, a low `req_pin` is the active level and a high pin is inactive.
- R3: With `req_edge`=1, an inactive-to-active transition of the synchronized pin sets a pending request. The pending request shows on `arb_req` one edge after synchronization and stays there until a cycle with `arb_gnt`=1. A pin that remains active afterwards raises no new request.
- R4: `ack_pin` equals `ack_active` when `ack_pol`=1 and its inverse when `ack_pol`=0. During channel reset, acknowledge is held at its inactive level.
- R5: With `done_mode`=2'b10 (output), `done_oe` is 1. The cycle after an edge that samples `tc_in`=1 on an enabled channel, `done_out` is 0 for one cycle; otherwise it is 1.
- R6: With `done_mode`=2'b11 (open-drain), `done_out` is 0 and `done_oe` is 1 only for the one-cycle drive after terminal count. The block's own low drive, seen back on `done_in`, raises no abort.
- R7: With `done_mode`=2'b01 or 2'b11, a high-to-low transition on `done_in` produces a one-cycle abort pulse three edges later (two synchronizer stages plus one register). It also sets the sticky `done_stat` bit.
- R8: With `done_mode`=2'b00, `done_in` has no effect: no abort and no status. `done_oe` is 0 and `done_out` is 1.
- R9: An external done gives `abort_chain` when `chain_done`=1 and `abort_cur` when `chain_done`=0, never both. An `abort_chain` also clears `chan_en`.
- R10: While `chan_rst`=1, `arb_req` is 0. On the following edge, `chan_en`, `xfer_active`, `done_stat`, the pending request and the abort pulses are all cleared.
- R11: `xfer_active` is set on an edge where `arb_gnt` and `arb_req` are both 1. It is cleared by `tc_in`, an external done or channel reset, with clearing taking priority.
- R12: An `en_set` pulse sets `chan_en`, except while `chan_rst`=1, when it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_rst | input | 1 | Channel reset control (register bit resets to 1) |
| en_set | input | 1 | Pulse that enables the channel |
| req_pol | input | 1 | 1: high request pin active, 0: low active |
| req_edge | input | 1 | 1: edge detection, 0: level detection |
| ack_pol | input | 1 | 1: acknowledge driven high when asserted, 0: low |
| done_mode | input | 2 | 00 ignored, 01 input, 10 output, 11 open-drain |
| chain_done | input | 1 | 1: external done ends the whole chain, 0: current set only |
| req_pin | input | 1 | Asynchronous request pin |
| ack_active | input | 1 | Acknowledge request from channel core |
| ack_pin | output | 1 | Acknowledge pin |
| done_in | input | 1 | Done pin value, active low |
| done_out | output | 1 | Done pin drive value |
| done_oe | output | 1 | Done pin output enable |
| arb_gnt | input | 1 | Grant from the arbiter |
| arb_req | output | 1 | Request to the arbiter |
| tc_in | input | 1 | Terminal count from the transfer engine |
| chan_en | output | 1 | Channel enable flag |
| xfer_active | output | 1 | Transfer active flag |
| abort_cur | output | 1 | Pulse: end current register-set transfer |
| abort_chain | output | 1 | Pulse: end whole chained transfer |
| done_stat | output | 1 | Sticky external-done status |

## Verification
The hardest case to reach is open-drain mode, where the block's own terminal-count pulse reappears on `done_in` two synchronizer edges later and must not be taken for an external done. The bench resolves the wire itself: it ties `done_in` low whenever the block pulls low, or when a separate external pull is asserted. This reproduces the echo with the correct latency. The bench then issues a genuine external pull in the same mode and checks that the abort appears. Edge-mode persistence is reached by holding the pin active through and after a grant, and confirming that no second request appears.

// File: rtl/dmahs_pkg.sv
package dmahs_pkg;

  typedef enum logic [1:0] {
    DONE_IGNORE = 2'b00,
    DONE_IN     = 2'b01,
    DONE_OUT    = 2'b10,
    DONE_OD     = 2'b11
  } done_mode_e;

  // Map a raw pin level to "active" under a programmable polarity.
  function automatic logic apply_pol(input logic lvl, input logic high_active);
    return high_active ? lvl : ~lvl;
  endfunction

  // Inactive-to-active transition between two samples.
  function automatic logic went_active(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

  function automatic logic mode_listens(input done_mode_e m);
    return (m == DONE_IN) || (m == DONE_OD);
  endfunction

  function automatic logic mode_drives(input done_mode_e m);
    return (m == DONE_OUT) || (m == DONE_OD);
  endfunction

endpackage

// File: rtl/dmahs_sync.sv
module dmahs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= {STAGES{RST_VAL}};
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/dmahs_req_cond.sv
module dmahs_req_cond
  import dmahs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_rst,
  input  logic run,
  input  logic req_pin,
  input  logic req_pol,
  input  logic req_edge,
  input  logic arb_gnt,
  output logic arb_req,
  output logic req_rise
);
  logic req_s;
  logic act;
  logic act_d;
  logic pending;

  dmahs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(req_pin), .q(req_s)
  );

  assign act      = apply_pol(req_s, req_pol);
  assign req_rise = went_active(act, act_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_d <= 1'b0;
    else        act_d <= act;
  end

  // Pending edge: a new edge wins over a grant in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        pending <= 1'b0;
    else if (chan_rst || !req_edge)    pending <= 1'b0;
    else if (req_rise && run)          pending <= 1'b1;
    else if (arb_gnt)                  pending <= 1'b0;
  end

  assign arb_req = ~chan_rst & run & (req_edge ? pending : act);
endmodule

// File: rtl/dmahs_done_ctrl.sv
module dmahs_done_ctrl
  import dmahs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_rst,
  input  logic       run,
  input  done_mode_e mode,
  input  logic       tc_in,
  input  logic       done_in,
  output logic       done_out,
  output logic       done_oe,
  output logic       drive_now,
  output logic       ext_hit
);
  logic              done_s;
  logic              done_s_d;
  logic              fell;
  logic [SYNC_STAGES-1:0] echo;

  dmahs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(done_in), .q(done_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_now <= 1'b0;
      done_s_d  <= 1'b1;
    end else begin
      drive_now <= ~chan_rst & run & tc_in & mode_drives(mode);
      done_s_d  <= done_s;
    end
  end

  // Delay line marking the cycle when our own pull reaches the detector.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) echo <= '0;
    else        echo <= {echo[SYNC_STAGES-2:0], drive_now};
  end

  assign fell    = went_active(~done_s, ~done_s_d);
  assign ext_hit = ~chan_rst & mode_listens(mode) & fell
                 & ~((mode == DONE_OD) & echo[SYNC_STAGES-1]);

  always_comb begin
    unique case (mode)
      DONE_OUT: begin done_oe = 1'b1;      done_out = ~drive_now; end
      DONE_OD:  begin done_oe = drive_now; done_out = 1'b0;       end
      default:  begin done_oe = 1'b0;      done_out = 1'b1;       end
    endcase
  end
endmodule

// File: rtl/dmahs_chan_state.sv
module dmahs_chan_state (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_rst,
  input  logic en_set,
  input  logic arb_gnt,
  input  logic arb_req,
  input  logic tc_in,
  input  logic ext_hit,
  input  logic chain_done,
  output logic chan_en,
  output logic xfer_active,
  output logic abort_cur,
  output logic abort_chain,
  output logic done_stat
);
  logic end_chain;
  logic end_cur;

  assign end_chain = ext_hit & chain_done;
  assign end_cur   = ext_hit & ~chain_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_en     <= 1'b0;
      xfer_active <= 1'b0;
      abort_cur   <= 1'b0;
      abort_chain <= 1'b0;
      done_stat   <= 1'b0;
    end else if (chan_rst) begin
      chan_en     <= 1'b0;
      xfer_active <= 1'b0;
      abort_cur   <= 1'b0;
      abort_chain <= 1'b0;
      done_stat   <= 1'b0;
    end else begin
      if (end_chain)   chan_en <= 1'b0;
      else if (en_set) chan_en <= 1'b1;

      if (tc_in || ext_hit)        xfer_active <= 1'b0;
      else if (arb_gnt && arb_req) xfer_active <= 1'b1;

      abort_cur   <= end_cur;
      abort_chain <= end_chain;
      if (ext_hit) done_stat <= 1'b1;
    end
  end
endmodule

// File: rtl/dmahs_chan.sv
module dmahs_chan
  import dmahs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_rst,
  input  logic       en_set,
  input  logic       req_pol,
  input  logic       req_edge,
  input  logic       ack_pol,
  input  logic [1:0] done_mode,
  input  logic       chain_done,
  input  logic       req_pin,
  input  logic       ack_active,
  output logic       ack_pin,
  input  logic       done_in,
  output logic       done_out,
  output logic       done_oe,
  input  logic       arb_gnt,
  output logic       arb_req,
  input  logic       tc_in,
  output logic       chan_en,
  output logic       xfer_active,
  output logic       abort_cur,
  output logic       abort_chain,
  output logic       done_stat
);
  // Named internal events, visible to the bound checker.
  logic       ext_hit;
  logic       done_drive;
  logic       req_rise;
  done_mode_e mode_q;

  assign mode_q  = done_mode_e'(done_mode);
  assign ack_pin = apply_pol(ack_active & ~chan_rst, ack_pol);

  dmahs_req_cond #(.SYNC_STAGES(SYNC_STAGES)) u_req (
    .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .run(chan_en),
    .req_pin(req_pin), .req_pol(req_pol), .req_edge(req_edge),
    .arb_gnt(arb_gnt), .arb_req(arb_req), .req_rise(req_rise)
  );

  dmahs_done_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_done (
    .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .run(chan_en),
    .mode(mode_q), .tc_in(tc_in), .done_in(done_in),
    .done_out(done_out), .done_oe(done_oe),
    .drive_now(done_drive), .ext_hit(ext_hit)
  );

  dmahs_chan_state u_state (
    .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .en_set(en_set),
    .arb_gnt(arb_gnt), .arb_req(arb_req), .tc_in(tc_in),
    .ext_hit(ext_hit), .chain_done(chain_done),
    .chan_en(chan_en), .xfer_active(xfer_active),
    .abort_cur(abort_cur), .abort_chain(abort_chain),
    .done_stat(done_stat)
  );
endmodule

// File: rtl/dmahs_chan_checks.sv
module dmahs_chan_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       chan_rst,
  input logic [1:0] done_mode,
  input logic       arb_req,
  input logic       arb_gnt,
  input logic       tc_in,
  input logic       done_out,
  input logic       done_oe,
  input logic       chan_en,
  input logic       xfer_active,
  input logic       abort_cur,
  input logic       abort_chain,
  input logic       done_stat,
  input logic       ext_hit
);
  AST_NO_REQ_IN_CHRST: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |-> !arb_req); // R10
  AST_STAT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> !done_stat); // R10
  AST_ABORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({abort_cur, abort_chain})); // R9
  AST_CHAIN_ABORT_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    abort_chain |-> !chan_en); // R9
  AST_ABORT_FOLLOWS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_hit && !chan_rst) |=> (abort_cur || abort_chain)); // R7
  AST_OD_ONLY_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (done_mode == 2'b11) |-> !(done_oe && done_out)); // R6
  AST_OUT_ALWAYS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done_mode == 2'b10) |-> done_oe); // R5
  AST_ACTIVE_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_gnt && arb_req && !tc_in && !ext_hit) |=> xfer_active); // R11
endmodule

bind dmahs_chan dmahs_chan_checks u_chk (.*);

// File: tb/dmahs_chan_bench.sv
module dmahs_chan_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_rst = 1'b1, en_set = 1'b0, req_pol = 1'b0, req_edge = 1'b0;
  logic ack_pol = 1'b0, chain_done = 1'b0, req_pin = 1'b0, ack_active = 1'b0;
  logic [1:0] done_mode = 2'b00;
  logic arb_gnt = 1'b0, tc_in = 1'b0, ext_done_n = 1'b1;
  logic done_in, ack_pin, done_out, done_oe, arb_req;
  logic chan_en, xfer_active, abort_cur, abort_chain, done_stat;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  // Resolved done wire: pulled low by the block or by an outside device.
  assign done_in = (done_oe && !done_out) ? 1'b0 : ext_done_n;

  dmahs_chan u_dmahs_chan (
    .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .en_set(en_set),
    .req_pol(req_pol), .req_edge(req_edge), .ack_pol(ack_pol),
    .done_mode(done_mode), .chain_done(chain_done), .req_pin(req_pin),
    .ack_active(ack_active), .ack_pin(ack_pin), .done_in(done_in),
    .done_out(done_out), .done_oe(done_oe), .arb_gnt(arb_gnt),
    .arb_req(arb_req), .tc_in(tc_in), .chan_en(chan_en),
    .xfer_active(xfer_active), .abort_cur(abort_cur),
    .abort_chain(abort_chain), .done_stat(done_stat)
  );

  // {req_pol, req_pin, ack_pol, ack_active, exp_arb_req, exp_ack_pin}
  localparam logic [5:0] LVL_VEC [8] = '{
    6'b1111_11, 6'b1010_00, 6'b0001_10, 6'b0100_01,
    6'b1100_11, 6'b0111_01, 6'b0010_10, 6'b1001_00
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic enable_chan();
    en_set = 1'b1; step(1); en_set = 1'b0;
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    // Reset state with channel reset held
    chk("R10", "arb_req in reset", arb_req, 1'b0);
    chk("R10", "chan_en in reset", chan_en, 1'b0);
    chk("R10", "done_stat in reset", done_stat, 1'b0);
    chk("R8",  "done_oe default mode", done_oe, 1'b0);
    chk("R4",  "ack_pin idle low-polarity", ack_pin, 1'b1);

    // R12: enable ignored while channel reset held
    enable_chan(); step(1);
    chk("R12", "chan_en after set in reset", chan_en, 1'b0);
    chan_rst = 1'b0; step(1);
    enable_chan();
    chk("R12", "chan_en after set", chan_en, 1'b1);

    // R1/R2/R4 level-mode table
    foreach (LVL_VEC[i]) begin
      {req_pol, req_pin, ack_pol, ack_active} = LVL_VEC[i][5:2];
      step(2);
      chk(req_pol ? "R1" : "R2", "arb_req level", arb_req, LVL_VEC[i][1]);
      chk("R4", "ack_pin", ack_pin, LVL_VEC[i][0]);
    end

    // R3 edge mode, R11 active flag
    req_pol = 1'b1; req_pin = 1'b0; req_edge = 1'b1; ack_active = 1'b0;
    step(3);
    chk("R3", "no request before edge", arb_req, 1'b0);
    req_pin = 1'b1; step(3);
    chk("R3", "edge raises request", arb_req, 1'b1);
    step(2);
    chk("R3", "request held until grant", arb_req, 1'b1);
    arb_gnt = 1'b1; step(1); arb_gnt = 1'b0;
    chk("R3", "grant clears request", arb_req, 1'b0);
    chk("R11", "active after grant", xfer_active, 1'b1);
    step(3);
    chk("R3", "held pin no new request", arb_req, 1'b0);
    tc_in = 1'b1; step(1); tc_in = 1'b0;
    chk("R11", "tc clears active", xfer_active, 1'b0);

    // R5 output mode
    done_mode = 2'b10; step(1);
    chk("R5", "out idle level", done_out, 1'b1);
    tc_in = 1'b1; step(1); tc_in = 1'b0;
    chk("R5", "out pulse low", done_out, 1'b0);
    chk("R5", "out enable", done_oe, 1'b1);
    step(1);
    chk("R5", "out pulse one cycle", done_out, 1'b1);

    // R6 open-drain, own echo masked
    done_mode = 2'b11; chain_done = 1'b0; step(1);
    chk("R6", "od idle oe", done_oe, 1'b0);
    tc_in = 1'b1; step(1); tc_in = 1'b0;
    chk("R6", "od drive oe", done_oe, 1'b1);
    chk("R6", "od drive low", done_out, 1'b0);
    step(1);
    chk("R6", "od release", done_oe, 1'b0);
    step(4);
    chk("R6", "no abort from own drive", abort_cur | abort_chain, 1'b0);
    chk("R6", "no status from own drive", done_stat, 1'b0);

    // R7/R9 external done in open-drain mode, current-set abort
    ext_done_n = 1'b0; step(3);
    chk("R7", "abort after three edges", abort_cur, 1'b1);
    chk("R9", "no chain abort", abort_chain, 1'b0);
    step(1); ext_done_n = 1'b1;
    chk("R7", "abort one cycle", abort_cur, 1'b0);
    chk("R7", "status sticky", done_stat, 1'b1);
    chk("R9", "enable kept on current abort", chan_en, 1'b1);

    // R10 channel reset clears state
    arb_gnt = 1'b0; req_pin = 1'b0; step(3); req_pin = 1'b1; step(3);
    chk("R10", "pending present before reset", arb_req, 1'b1);
    chan_rst = 1'b1; #1;
    chk("R10", "arb_req dropped in reset", arb_req, 1'b0);
    step(1);
    chk("R10", "status cleared", done_stat, 1'b0);
    chk("R10", "enable cleared", chan_en, 1'b0);
    chan_rst = 1'b0; step(1); enable_chan(); step(1);
    chk("R10", "pending withdrawn", arb_req, 1'b0);

    // R7/R9 input mode, chain abort
    done_mode = 2'b01; chain_done = 1'b1; step(2);
    ext_done_n = 1'b0; step(3);
    chk("R9", "chain abort", abort_chain, 1'b1);
    chk("R9", "no current abort", abort_cur, 1'b0);
    chk("R9", "chain abort clears enable", chan_en, 1'b0);
    step(1); ext_done_n = 1'b1;
    chk("R7", "input-mode status", done_stat, 1'b1);

    // R8 ignored mode
    chan_rst = 1'b1; step(1); chan_rst = 1'b0; step(1); enable_chan();
    done_mode = 2'b00; step(2);
    ext_done_n = 1'b0; step(5);
    chk("R8", "ignored no abort", abort_cur | abort_chain, 1'b0);
    chk("R8", "ignored no status", done_stat, 1'b0);
    tc_in = 1'b1; step(1); tc_in = 1'b0;
    chk("R8", "ignored oe", done_oe, 1'b0);
    chk("R8", "ignored out", done_out, 1'b1);
    ext_done_n = 1'b1;

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule